// File: doc/BRIEF.md
# Memory Barrier Issue Controller

This block handles one memory barrier instruction at a time in a processor whose memory operations are performed in program order. It takes the 7-bit barrier mask, sorts it into one of a small set of wait classes, and raises stall signals. The stalls hold back later loads, later stores, or every later instruction until the completion condition for that class is observed. When the wait is over, the block emits a one-cycle retire pulse. The rest of the machine is seen only through status inputs: store-buffer occupancy, count of outstanding earlier loads, a busy flag for in-flight non-memory operations and a flag for exceptions not yet reported.

Memory is already ordered, so three of the four ordering bits cost nothing. Only the store-to-load bit waits, and it waits only for the store buffer to drain. All three completion bits are folded into one full-drain wait, which holds every later instruction until all earlier work has finished and all exceptions have been reported. A flush input drops a waiting barrier. While a barrier waits, a second one is turned away through the all-instruction stall.

Top module: `membar_ctrl`

## Requirements
- R1: During and directly after reset, stall_load, stall_store, stall_all and retire are all low.
- R2: A barrier is accepted when issue_valid is high, no barrier is waiting and flush is low. If any completion bit (mask bits 6, 5, 4) is set, stall_load, stall_store and stall_all are all high from the cycle after acceptance until the barrier retires.
- R3: A barrier with all completion bits clear and ordering bit 1 clear raises no stall. Its ordering bits 3, 2 and 0 may be set in any combination, or the mask may be all zero. Its retire is high in the cycle after acceptance, whatever the status inputs show.
- R4: A barrier with all completion bits clear and ordering bit 1 (store-then-load) set raises only stall_load, with stall_store and stall_all low. The load counter, the non-memory busy flag and the exception flag have no effect on it.
- R5: A waiting store-then-load barrier retires in the cycle after the first cycle in which sb_count is zero. Its stall_load falls in that same retire cycle.
- R6: A full-drain barrier retires in the cycle after the first cycle in which sb_count and ld_count are both zero and nonmem_busy and exc_pending are both low. While any one of these four is not met, it keeps waiting.
- R7: Retire is never high in a cycle where stall_load or stall_all is high.
- R8: flush high in a cycle cancels any waiting barrier. In the next cycle all stalls are low and retire is low.
- R9: While a barrier waits, issue_valid high makes stall_all high in that same cycle. The new barrier is not accepted until the waiting one has retired.
- R10: When completion bits and ordering bit 1 are both set, the full-drain wait governs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | A barrier instruction is presented for issue |
| issue_mask | input | 7 | Barrier mask: bits 6..4 completion, bits 3..0 ordering |
| sb_count | input | SB_CNT_W | Entries held in the store buffer |
| ld_count | input | LD_CNT_W | Earlier loads not yet performed |
| nonmem_busy | input | 1 | Earlier non-memory operations still in flight |
| exc_pending | input | 1 | Exceptions from earlier operations not yet reported |
| flush | input | 1 | Pipeline flush, cancels a waiting barrier |
| stall_load | output | 1 | Hold back later loads |
| stall_store | output | 1 | Hold back later stores |
| stall_all | output | 1 | Hold back every later instruction |
| retire | output | 1 | One-cycle pulse: the barrier has retired |

## Verification
A wrongly held wait class shows up one cycle after acceptance as the wrong set of stall outputs. For example, a store-then-load barrier that drove stall_store would be caught, and so would a completion barrier that dropped stall_all. A waiting flag stuck high or low shows up as a missing or early retire pulse in the cycle after the status inputs change. The bench clears the drain conditions one at a time, so a single unchecked condition gives an early retire. A flush that fails to clear the state leaves a stall high in the very next cycle.

// File: rtl/membar_pkg.sv
// Shared definitions for the memory barrier issue controller.
// Holds the mask layout and the wait classes that the decoder produces.
package membar_pkg;

    localparam int ORD_W   = 4;                // ordering bits
    localparam int CMP_W   = 3;                // completion bits
    localparam int MASK_W  = ORD_W + CMP_W;    // whole barrier mask
    localparam int CMP_LSB = ORD_W;            // first completion bit
    localparam int ORD_STLD = 1;               // store-then-load ordering bit

    // Wait class of a barrier, strongest last
    typedef enum logic [1:0] {
        WAIT_EMPTY = 2'd0,   // both masks zero
        WAIT_FREE  = 2'd1,   // only ordering bits that memory order already honours
        WAIT_STLD  = 2'd2,   // later loads wait for the store buffer to drain
        WAIT_DRAIN = 2'd3    // every later instruction waits for full completion
    } wait_kind_t;

endpackage

// File: rtl/membar_decode.sv
// Barrier mask decoder.
// Sorts the 7-bit mask into a wait class; the strongest applicable class wins.
// Assumes memory operations are performed in program order, so only the
// store-then-load ordering bit needs a wait.
module membar_decode
    import membar_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    output wait_kind_t        kind
);

    logic [CMP_W-1:0] cmp_bits;
    logic [ORD_W-1:0] ord_bits;
    logic [ORD_W-1:0] ord_free_bits;

    assign cmp_bits = mask[MASK_W-1:CMP_LSB];
    assign ord_bits = mask[ORD_W-1:0];

    // Mark the ordering bits that cost nothing on in-order memory
    always_comb begin
        ord_free_bits           = ord_bits;
        ord_free_bits[ORD_STLD] = 1'b0;
    end

    // Choose the strongest wait class called for by the mask
    always_comb begin
        if (|cmp_bits)
            kind = WAIT_DRAIN;
        else if (ord_bits[ORD_STLD])
            kind = WAIT_STLD;
        else if (|ord_free_bits)
            kind = WAIT_FREE;
        else
            kind = WAIT_EMPTY;
    end

endmodule

// File: rtl/membar_cond.sv
// Completion condition evaluator.
// Says whether the wait of a given class is satisfied by the current
// pipeline status. Immediate classes are always satisfied.
module membar_cond
    import membar_pkg::*;
#(
    parameter int SB_CNT_W = 4,
    parameter int LD_CNT_W = 3
) (
    input  wait_kind_t          kind,
    input  logic [SB_CNT_W-1:0] sb_count,
    input  logic [LD_CNT_W-1:0] ld_count,
    input  logic                nonmem_busy,
    input  logic                exc_pending,
    output logic                met
);

    logic sb_drained;
    logic all_drained;

    assign sb_drained  = (sb_count == '0);
    assign all_drained = sb_drained && (ld_count == '0) && !nonmem_busy && !exc_pending;

    // Pick the condition that matches the wait class
    always_comb begin
        unique case (kind)
            WAIT_STLD:  met = sb_drained;
            WAIT_DRAIN: met = all_drained;
            default:    met = 1'b1;
        endcase
    end

endmodule

// File: rtl/membar_seq.sv
// Barrier sequencer.
// Accepts one barrier at a time, holds its wait class while it waits, and
// produces the registered retire pulse. Flush has priority over all else.
module membar_seq
    import membar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_valid,
    input  wait_kind_t issue_kind,
    input  logic       held_met,
    input  logic       flush,
    output logic       pending,
    output wait_kind_t held_kind,
    output logic       retire
);

    logic accept;
    logic issue_immediate;

    assign accept          = issue_valid && !pending && !flush;
    assign issue_immediate = (issue_kind == WAIT_EMPTY) || (issue_kind == WAIT_FREE);

    // Track the waiting barrier and its class
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pending   <= 1'b0;
            held_kind <= WAIT_EMPTY;
        end else if (pending) begin
            if (held_met) begin
                pending   <= 1'b0;
                held_kind <= WAIT_EMPTY;
            end
        end else if (accept && !issue_immediate) begin
            pending   <= 1'b1;
            held_kind <= issue_kind;
        end
    end

    // Retire one cycle after the condition is seen, or right after an immediate accept
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            retire <= 1'b0;
        else
            retire <= (pending && held_met) || (accept && issue_immediate);
    end

endmodule

// File: rtl/membar_ctrl.sv
// Memory barrier issue controller, top level.
// Decodes the barrier mask, waits for the completion condition and drives
// load, store and all-instruction stalls plus a retire pulse.
// Assumes in-order memory operations and at most one barrier waiting.
module membar_ctrl
    import membar_pkg::*;
#(
    parameter int SB_CNT_W = 4,
    parameter int LD_CNT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [MASK_W-1:0]   issue_mask,
    input  logic [SB_CNT_W-1:0] sb_count,
    input  logic [LD_CNT_W-1:0] ld_count,
    input  logic                nonmem_busy,
    input  logic                exc_pending,
    input  logic                flush,
    output logic                stall_load,
    output logic                stall_store,
    output logic                stall_all,
    output logic                retire
);

    wait_kind_t issue_kind;
    wait_kind_t held_kind;
    logic       held_met;
    logic       pending;

    membar_decode i_decode (
        .mask (issue_mask),
        .kind (issue_kind)
    );

    membar_cond #(
        .SB_CNT_W (SB_CNT_W),
        .LD_CNT_W (LD_CNT_W)
    ) i_cond (
        .kind        (held_kind),
        .sb_count    (sb_count),
        .ld_count    (ld_count),
        .nonmem_busy (nonmem_busy),
        .exc_pending (exc_pending),
        .met         (held_met)
    );

    membar_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_kind  (issue_kind),
        .held_met    (held_met),
        .flush       (flush),
        .pending     (pending),
        .held_kind   (held_kind),
        .retire      (retire)
    );

    // Stalls follow the held wait class; a second barrier is held off by stall_all
    always_comb begin
        stall_load  = pending;
        stall_store = pending && (held_kind == WAIT_DRAIN);
        stall_all   = stall_store || (pending && issue_valid);
    end

endmodule

// File: rtl/membar_ctrl_chk.sv
// Property checker for the memory barrier issue controller, bound to the top.
module membar_ctrl_chk #(
    parameter int SB_CNT_W = 4,
    parameter int LD_CNT_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                issue_valid,
    input logic [6:0]          issue_mask,
    input logic [SB_CNT_W-1:0] sb_count,
    input logic [LD_CNT_W-1:0] ld_count,
    input logic                nonmem_busy,
    input logic                exc_pending,
    input logic                flush,
    input logic                stall_load,
    input logic                stall_store,
    input logic                stall_all,
    input logic                retire
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!stall_load && !stall_store && !stall_all && !retire));

    // R2
    drain_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall_all && !flush && (issue_mask[6:4] != 3'b000))
        |=> (stall_all && stall_store && stall_load));

    // R3
    free_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall_all && !flush && (issue_mask[6:4] == 3'b000) && !issue_mask[1])
        |=> (retire && !stall_load));

    // R4
    store_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_store |-> (stall_load && stall_all));

    // R5
    stld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_load && !stall_store && (sb_count != '0) && !flush) |=> stall_load);

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_store && !flush && ((sb_count != '0) || (ld_count != '0) || nonmem_busy || exc_pending))
        |=> stall_store);

    // R7
    retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (!stall_load && !stall_all));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!stall_load && !stall_store && !retire));

    // R9
    second_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_load && issue_valid) |-> stall_all);

endmodule

bind membar_ctrl membar_ctrl_chk #(
    .SB_CNT_W (SB_CNT_W),
    .LD_CNT_W (LD_CNT_W)
) i_membar_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_mask  (issue_mask),
    .sb_count    (sb_count),
    .ld_count    (ld_count),
    .nonmem_busy (nonmem_busy),
    .exc_pending (exc_pending),
    .flush       (flush),
    .stall_load  (stall_load),
    .stall_store (stall_store),
    .stall_all   (stall_all),
    .retire      (retire)
);

// File: tb/test_membar_ctrl.sv
// Directed bench for the memory barrier issue controller.
module test_membar_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SB_W = 4;
    localparam int LD_W = 3;
    localparam int WATCHDOG = 100000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            issue_valid;
    logic [6:0]      issue_mask;
    logic [SB_W-1:0] sb_count;
    logic [LD_W-1:0] ld_count;
    logic            nonmem_busy;
    logic            exc_pending;
    logic            flush;
    logic            stall_load;
    logic            stall_store;
    logic            stall_all;
    logic            retire;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    membar_ctrl #(.SB_CNT_W(SB_W), .LD_CNT_W(LD_W)) i_membar_ctrl (
        .clk (clk), .rst_n (rst_n), .issue_valid (issue_valid), .issue_mask (issue_mask),
        .sb_count (sb_count), .ld_count (ld_count), .nonmem_busy (nonmem_busy),
        .exc_pending (exc_pending), .flush (flush), .stall_load (stall_load),
        .stall_store (stall_store), .stall_all (stall_all), .retire (retire)
    );

    // Advance one clock and settle away from the edge
    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Compare all four outputs at once
    task automatic check_out(input string req, input logic e_ld, input logic e_st,
                             input logic e_all, input logic e_ret);
        check(req, "stall_load",  stall_load,  e_ld);
        check(req, "stall_store", stall_store, e_st);
        check(req, "stall_all",   stall_all,   e_all);
        check(req, "retire",      retire,      e_ret);
    endtask

    task automatic idle_inputs();
        issue_valid = 1'b0; issue_mask = '0; sb_count = '0; ld_count = '0;
        nonmem_busy = 1'b0; exc_pending = 1'b0; flush = 1'b0;
    endtask

    // Present a barrier for one cycle (accepted at the next edge)
    task automatic issue(input logic [6:0] m);
        issue_valid = 1'b1; issue_mask = m;
        tick();
        issue_valid = 1'b0; issue_mask = '0;
        #1;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        issue_valid = 1'b1; issue_mask = 7'h7F;
        tick(); tick();
        check_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        issue_valid = 1'b0; issue_mask = '0;
        rst_n = 1'b1;
        tick();
        check_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_free();
        logic [6:0] masks [4] = '{7'b000_0000, 7'b000_1101, 7'b000_1000, 7'b000_0001};
        sb_count = 4'd5; ld_count = 3'd2; nonmem_busy = 1'b1; exc_pending = 1'b1;
        foreach (masks[i]) begin
            issue(masks[i]);
            check_out("R3", 1'b0, 1'b0, 1'b0, 1'b1);
            tick();
            check_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        idle_inputs();
    endtask

    task automatic t_store_load();
        sb_count = 4'd3; ld_count = 3'd2; nonmem_busy = 1'b1; exc_pending = 1'b1;
        issue(7'b000_0010);
        check_out("R4", 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            tick();
            check_out("R4", 1'b1, 1'b0, 1'b0, 1'b0);
        end
        sb_count = 4'd0;
        tick();
        check_out("R5", 1'b0, 1'b0, 1'b0, 1'b1);
        tick();
        check_out("R5", 1'b0, 1'b0, 1'b0, 1'b0);
        idle_inputs();
    endtask

    task automatic t_drain();
        for (int b = 4; b < 7; b++) begin
            sb_count = 4'd1; ld_count = 3'd1; nonmem_busy = 1'b1; exc_pending = 1'b1;
            issue(7'(1 << b));
            check_out("R2", 1'b1, 1'b1, 1'b1, 1'b0);
            sb_count = 4'd0; tick();
            check_out("R6", 1'b1, 1'b1, 1'b1, 1'b0);
            ld_count = 3'd0; tick();
            check_out("R6", 1'b1, 1'b1, 1'b1, 1'b0);
            nonmem_busy = 1'b0; tick();
            check_out("R6", 1'b1, 1'b1, 1'b1, 1'b0);
            exc_pending = 1'b0; tick();
            check_out("R6", 1'b0, 1'b0, 1'b0, 1'b1);
            tick();
            check_out("R7", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        idle_inputs();
    endtask

    task automatic t_strongest();
        sb_count = 4'd0; ld_count = 3'd1;
        issue(7'b010_0010);
        check_out("R10", 1'b1, 1'b1, 1'b1, 1'b0);
        tick();
        check_out("R10", 1'b1, 1'b1, 1'b1, 1'b0);
        ld_count = 3'd0; tick();
        check_out("R10", 1'b0, 1'b0, 1'b0, 1'b1);
        idle_inputs();
        tick();
    endtask

    task automatic t_flush();
        sb_count = 4'd2; nonmem_busy = 1'b1;
        issue(7'b100_0000);
        check_out("R8", 1'b1, 1'b1, 1'b1, 1'b0);
        flush = 1'b1; tick(); flush = 1'b0;
        check_out("R8", 1'b0, 1'b0, 1'b0, 1'b0);
        idle_inputs(); tick();
        check_out("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_second();
        int retires = 0;
        sb_count = 4'd2;
        issue(7'b000_0010);
        check_out("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        issue_valid = 1'b1; issue_mask = 7'b000_0000; #1;
        check("R9", "stall_all while waiting", stall_all, 1'b1);
        tick();
        check_out("R9", 1'b1, 1'b0, 1'b1, 1'b0);
        sb_count = 4'd0; tick();
        check("R9", "first retire", retire, 1'b1);
        retires += int'(retire);
        check("R9", "stall_all released", stall_all, 1'b0);
        tick();
        check("R9", "second retire", retire, 1'b1);
        retires += int'(retire);
        issue_valid = 1'b0; tick();
        check("R9", "no extra retire", retire, 1'b0);
        n_checks++;
        if (retires != 2) begin
            n_fails++;
            $display("FAIL R9 retire count: actual %0d expected 2", retires);
        end
        idle_inputs();
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_free();
        t_store_load();
        t_drain();
        t_strongest();
        t_flush();
        t_second();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule